// File: doc/BRIEF.md
# NAND Flash Bus Cycle Controller

This block connects a simple register-mapped host port to an 8-bit NAND flash device. The host programs three phase lengths: setup, strobe-active and hold. It controls the active-low chip enable through a control bit, and it can restart an external parity accumulator. It then issues flash operations one byte at a time by writing the command register, writing the address register, or reading or writing the data register. Each such access becomes one bus cycle. The latch-enable lines and the data bus are held for the whole cycle, and the write or read strobe is low only during the active phase.

Each phase length is stored as its cycle count minus one, so a stored zero gives one clock. The setup field has 2 bits and covers 1 to 4 cycles. The active and hold fields have 3 bits each and cover 1 to 8 cycles. After reset every field holds its maximum. The flash ready/busy pin passes through a two-flop synchronizer and appears as a status bit. The block does not sequence flash commands and does not compute ECC. It does emit a strobe carrying every data byte, so that an outside parity engine can follow the data.

The sequencer is a four-state machine. ST_IDLE goes to ST_SETUP when a bus access is requested. ST_SETUP goes to ST_ACTIVE when its counter reaches zero. ST_ACTIVE goes to ST_HOLD when its counter reaches zero, and on that edge a read byte is captured. ST_HOLD goes back to ST_IDLE when its counter reaches zero, which is the cycle in which the host is acknowledged. In every other case the state holds and the counter decrements.

Top module: `nand_cycle_ctrl`

## Requirements
- R1: After reset the timing register reads 0xFF (setup 4, active 8, hold 8 cycles), nand_ce_n is 1, nand_we_n and nand_re_n are 1, nand_cle, nand_ale and nand_dq_oe are 0.
- R2: The timing register (address 0) holds setup-1 in bits [1:0], active-1 in bits [4:2] and hold-1 in bits [7:5]. A bus cycle spends exactly field+1 clocks in each phase, and the register reads back what was written.
- R3: A write to the command register (address 2) makes a cycle with nand_cle high through setup, active and hold, nand_ale low, nand_we_n low for the active cycles only, and the byte driven on nand_dq_out with nand_dq_oe high.
- R4: A write to the address register (address 3) makes the same cycle with nand_ale high in place of nand_cle.
- R5: A write to the data register (address 4) makes a cycle with nand_cle and nand_ale both low, nand_we_n pulsed for the active cycles, and the byte driven with nand_dq_oe high.
- R6: A read of the data register makes a cycle with nand_re_n low for the active cycles and nand_dq_oe low. The byte present on nand_dq_in in the last active cycle (the clock edge at which nand_re_n rises) is returned in host_rdata.
- R7: Accesses to the timing and control registers are acknowledged in the cycle of the request. A bus access is acknowledged only in the last hold cycle, which is 1 + setup + active + hold cycles after the request first appears.
- R8: Control register (address 1) bit 0 drives nand_ce_n directly: writing 1 deasserts the chip enable and writing 0 asserts it. Reads of bit 0 return the current value.
- R9: Writing control bit 1 as 1 raises ecc_restart for exactly one cycle, following the accepted write. Writing it as 0 produces no pulse, and bit 1 always reads as 0.
- R10: Control register bit 7 reads the ready/busy pin (1 ready, 0 busy) two clock edges after the pin changes.
- R11: ecc_byte_vld pulses once per data read or data write, in the acknowledge cycle, with ecc_byte carrying the transferred byte. It never pulses for command or address cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 3 | Register select: 0 timing, 1 control/status, 2 command, 3 address, 4 data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_ack |
| host_ack | output | 1 | Access completes at the clock edge where host_req and host_ack are both high |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy pin, 1 ready |
| ecc_restart | output | 1 | One-cycle pulse that restarts the external parity run |
| ecc_byte_vld | output | 1 | A data byte has been transferred |
| ecc_byte | output | 8 | The transferred data byte |

## Verification
A phase counter that loads the wrong field, or that stops one count early or late, changes the position of the strobe edge in the same bus cycle. It also moves the acknowledge by the same number of clocks, so the bench counts strobe-low, latch-high and post-strobe cycles for every access and compares them with the programmed values. A read capture taken on the wrong edge returns a byte that the bench's counting data pattern tells apart, in the acknowledge cycle. A stuck operation register shows up on the latch-enable and strobe pins during the very next access. Synchronizer and control-bit faults appear at the next control read, within two clocks.

// File: rtl/nandc_pkg.sv
package nandc_pkg;

    localparam int HOST_AW = 3;

    localparam logic [HOST_AW-1:0] RG_TIMING = 3'd0;
    localparam logic [HOST_AW-1:0] RG_CTRL   = 3'd1;
    localparam logic [HOST_AW-1:0] RG_CMD    = 3'd2;
    localparam logic [HOST_AW-1:0] RG_ADDR   = 3'd3;
    localparam logic [HOST_AW-1:0] RG_DATA   = 3'd4;

    typedef enum logic [1:0] {
        OP_CMD = 2'd0,
        OP_ADR = 2'd1,
        OP_WR  = 2'd2,
        OP_RD  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/nandc_regs.sv
module nandc_regs #(
    parameter int SETUP_W = 2,
    parameter int PULSE_W = 3,
    parameter int HOLD_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_timing,
    input  logic               wr_ctrl,
    input  logic [SETUP_W+PULSE_W+HOLD_W-1:0] timing_wdata,
    input  logic [1:0]         ctrl_wdata,
    output logic [SETUP_W-1:0] tim_setup,
    output logic [PULSE_W-1:0] tim_pulse,
    output logic [HOLD_W-1:0]  tim_hold,
    output logic               ce_n,
    output logic               ecc_restart
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_setup   <= '1;
            tim_pulse   <= '1;
            tim_hold    <= '1;
            ce_n        <= 1'b1;
            ecc_restart <= 1'b0;
        end else begin
            ecc_restart <= wr_ctrl && ctrl_wdata[1];
            if (wr_timing) begin
                {tim_hold, tim_pulse, tim_setup} <= timing_wdata;
            end
            if (wr_ctrl) begin
                ce_n <= ctrl_wdata[0];
            end
        end
    end

endmodule

// File: rtl/nandc_rbsync.sv
module nandc_rbsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_pin,
    output logic rb_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], rb_pin};
        end
    end

    assign rb_sync = chain[STAGES-1];

endmodule

// File: rtl/nandc_seq.sv
module nandc_seq
    import nandc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 2,
    parameter int PULSE_W = 3,
    parameter int HOLD_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  bus_op_e            op_in,
    input  logic [DATA_W-1:0]  wbyte,
    input  logic [SETUP_W-1:0] tim_setup,
    input  logic [PULSE_W-1:0] tim_pulse,
    input  logic [HOLD_W-1:0]  tim_hold,
    input  logic [DATA_W-1:0]  dq_in,
    output logic               idle,
    output logic               done,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe,
    output logic [DATA_W-1:0]  rd_byte,
    output logic               byte_vld,
    output logic [DATA_W-1:0]  byte_val
);

    localparam int MAX_SP = (SETUP_W > PULSE_W) ? SETUP_W : PULSE_W;
    localparam int CNT_W  = (MAX_SP > HOLD_W) ? MAX_SP : HOLD_W;

    seq_state_e          state;
    seq_state_e          state_nxt;
    logic [CNT_W-1:0]    cnt;
    logic                cnt_zero;
    bus_op_e             op_q;
    logic [DATA_W-1:0]   wq;
    logic [DATA_W-1:0]   rq;

    assign cnt_zero = (cnt == '0);

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start)    state_nxt = ST_SETUP;
            ST_SETUP:  if (cnt_zero) state_nxt = ST_ACTIVE;
            ST_ACTIVE: if (cnt_zero) state_nxt = ST_HOLD;
            ST_HOLD:   if (cnt_zero) state_nxt = ST_IDLE;
        endcase
    end

    // state register with phase counter and byte latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            op_q  <= OP_CMD;
            wq    <= '0;
            rq    <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE) begin
                if (start) begin
                    cnt  <= CNT_W'(tim_setup);
                    op_q <= op_in;
                    wq   <= wbyte;
                end
            end else if (cnt_zero) begin
                if (state == ST_SETUP) begin
                    cnt <= CNT_W'(tim_pulse);
                end else if (state == ST_ACTIVE) begin
                    cnt <= CNT_W'(tim_hold);
                    if (op_q == OP_RD) begin
                        rq <= dq_in;
                    end
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // outputs from state
    always_comb begin
        idle     = (state == ST_IDLE);
        done     = (state == ST_HOLD) && cnt_zero;
        cle      = !idle && (op_q == OP_CMD);
        ale      = !idle && (op_q == OP_ADR);
        we_n     = !((state == ST_ACTIVE) && (op_q != OP_RD));
        re_n     = !((state == ST_ACTIVE) && (op_q == OP_RD));
        dq_oe    = !idle && (op_q != OP_RD);
        dq_out   = wq;
        rd_byte  = rq;
        byte_vld = done && ((op_q == OP_WR) || (op_q == OP_RD));
        byte_val = (op_q == OP_RD) ? rq : wq;
    end

endmodule

// File: rtl/nand_cycle_ctrl.sv
module nand_cycle_ctrl
    import nandc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 2,
    parameter int PULSE_W = 3,
    parameter int HOLD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ack,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb,
    output logic              ecc_restart,
    output logic              ecc_byte_vld,
    output logic [DATA_W-1:0] ecc_byte
);

    localparam int TIM_W = SETUP_W + PULSE_W + HOLD_W;

    logic [SETUP_W-1:0] tim_setup;
    logic [PULSE_W-1:0] tim_pulse;
    logic [HOLD_W-1:0]  tim_hold;
    logic               rb_sync;
    logic               seq_idle;
    logic               seq_done;
    logic [DATA_W-1:0]  rd_byte;
    logic               is_bus;
    logic               reg_ok;
    logic               start;
    bus_op_e            op_sel;

    // access decode
    always_comb begin
        is_bus = host_req && ((host_we && ((host_addr == RG_CMD) || (host_addr == RG_ADDR)))
                              || (host_addr == RG_DATA));
        reg_ok = host_req && !is_bus && seq_idle;
        start  = is_bus && seq_idle;
        if (host_addr == RG_CMD)       op_sel = OP_CMD;
        else if (host_addr == RG_ADDR) op_sel = OP_ADR;
        else if (host_we)              op_sel = OP_WR;
        else                           op_sel = OP_RD;
        host_ack = is_bus ? seq_done : reg_ok;
        host_rdata = '0;
        if (host_addr == RG_TIMING)
            host_rdata = DATA_W'({tim_hold, tim_pulse, tim_setup});
        else if (host_addr == RG_CTRL)
            host_rdata = {rb_sync, {(DATA_W-2){1'b0}}, nand_ce_n};
        else if (host_addr == RG_DATA)
            host_rdata = rd_byte;
    end

    nandc_regs #(
        .SETUP_W (SETUP_W),
        .PULSE_W (PULSE_W),
        .HOLD_W  (HOLD_W)
    ) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_timing    (reg_ok && host_we && (host_addr == RG_TIMING)),
        .wr_ctrl      (reg_ok && host_we && (host_addr == RG_CTRL)),
        .timing_wdata (host_wdata[TIM_W-1:0]),
        .ctrl_wdata   (host_wdata[1:0]),
        .tim_setup    (tim_setup),
        .tim_pulse    (tim_pulse),
        .tim_hold     (tim_hold),
        .ce_n         (nand_ce_n),
        .ecc_restart  (ecc_restart)
    );

    nandc_rbsync #(
        .STAGES (2)
    ) i_rbsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rb_pin  (nand_rb),
        .rb_sync (rb_sync)
    );

    nandc_seq #(
        .DATA_W  (DATA_W),
        .SETUP_W (SETUP_W),
        .PULSE_W (PULSE_W),
        .HOLD_W  (HOLD_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_in     (op_sel),
        .wbyte     (host_wdata),
        .tim_setup (tim_setup),
        .tim_pulse (tim_pulse),
        .tim_hold  (tim_hold),
        .dq_in     (nand_dq_in),
        .idle      (seq_idle),
        .done      (seq_done),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .dq_out    (nand_dq_out),
        .dq_oe     (nand_dq_oe),
        .rd_byte   (rd_byte),
        .byte_vld  (ecc_byte_vld),
        .byte_val  (ecc_byte)
    );

endmodule

// File: rtl/nand_cycle_ctrl_chk.sv
module nand_cycle_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic [2:0]        host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_ack,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic [DATA_W-1:0] nand_dq_out,
    input logic              nand_dq_oe,
    input logic              nand_rb,
    input logic              ecc_restart,
    input logic              ecc_byte_vld
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)) else $error("cle and ale both high"); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)) else $error("both strobes low"); // R6

    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe) else $error("write strobe without drive"); // R5

    AST_RE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe) else $error("read strobe while driving"); // R6

    AST_DQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out)) else $error("dq moved under strobe"); // R3

    AST_ACK_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ack) |-> (nand_we_n && nand_re_n)) else $error("ack during active phase"); // R7

    AST_ECC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_restart |=> !ecc_restart) else $error("restart pulse too long"); // R9

    AST_ECC_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_byte_vld |-> (host_req && host_ack)) else $error("byte strobe outside ack"); // R11

    AST_RB_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && host_req && !host_we && (host_addr == 3'd1) && host_ack)
        |-> (host_rdata[DATA_W-1] == $past(nand_rb, 2))) else $error("ready bit lag wrong"); // R10

endmodule

bind nand_cycle_ctrl nand_cycle_ctrl_chk i_chk (.*);

// File: tb/test_nand_cycle_ctrl.sv
module test_nand_cycle_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ack;
    logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out;
    logic [7:0] nand_dq_in = '0;
    logic       nand_rb = 1'b1;
    logic       ecc_restart, ecc_byte_vld;
    logic [7:0] ecc_byte;

    int checks = 0;
    int errors = 0;

    // monitor results of the last access
    int m_tot, m_we, m_re, m_post, m_cle, m_ale, m_ecc, m_bad;
    logic [7:0] m_dq, m_eccb, m_rd;

    always #4 clk = ~clk;

    nand_cycle_ctrl i_nand_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb(nand_rb), .ecc_restart(ecc_restart), .ecc_byte_vld(ecc_byte_vld),
        .ecc_byte(ecc_byte)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] a, input logic w, input logic [7:0] d,
                          input logic [7:0] pat);
        int idx;
        bit seen;
        @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
        m_tot = 0; m_we = 0; m_re = 0; m_post = 0; m_cle = 0; m_ale = 0;
        m_ecc = 0; m_bad = 0; m_dq = '0; m_eccb = '0; m_rd = '0;
        idx = 0; seen = 0;
        forever begin
            #1;
            m_tot++;
            if (!nand_we_n) begin
                m_we++; m_dq = nand_dq_out;
                if (!nand_dq_oe) m_bad++;
            end
            if (!nand_re_n) begin
                m_re++; nand_dq_in = pat ^ 8'(idx); idx++;
            end
            if (!nand_we_n || !nand_re_n) seen = 1;
            else if (seen) m_post++;
            if (nand_cle) m_cle++;
            if (nand_ale) m_ale++;
            if (ecc_byte_vld) begin m_ecc++; m_eccb = ecc_byte; end
            if (host_ack) begin m_rd = host_rdata; break; end
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ce_n", nand_ce_n, 1);
        chk("R1 we_n", nand_we_n, 1);
        chk("R1 re_n", nand_re_n, 1);
        chk("R1 cle|ale|oe", {nand_cle, nand_ale, nand_dq_oe}, 0);
        access(3'd0, 1'b0, 8'h00, 8'h00);
        chk("R1 timing reset", m_rd, 8'hFF);
        chk("R7 reg ack first cycle", m_tot, 1);
        access(3'd1, 1'b0, 8'h00, 8'h00);
        chk("R8 ctrl bit0 reset", m_rd[0], 1);
    endtask

    task automatic t_cmd_default();
        access(3'd2, 1'b1, 8'h70, 8'h00);
        chk("R7 cmd total", m_tot, 21);
        chk("R2 active default", m_we, 8);
        chk("R2 hold default", m_post, 8);
        chk("R2 setup default", m_tot - 1 - m_we - m_post, 4);
        chk("R3 cle cycles", m_cle, 20);
        chk("R3 ale low", m_ale, 0);
        chk("R3 dq byte", m_dq, 8'h70);
        chk("R3 oe under strobe", m_bad, 0);
        chk("R11 no byte strobe on cmd", m_ecc, 0);
    endtask

    task automatic t_addr_prog();
        access(3'd0, 1'b1, 8'h44, 8'h00);
        access(3'd0, 1'b0, 8'h00, 8'h00);
        chk("R2 timing readback", m_rd, 8'h44);
        access(3'd3, 1'b1, 8'hA5, 8'h00);
        chk("R7 addr total", m_tot, 7);
        chk("R2 active 2", m_we, 2);
        chk("R2 hold 3", m_post, 3);
        chk("R2 setup 1", m_tot - 1 - m_we - m_post, 1);
        chk("R4 ale cycles", m_ale, 6);
        chk("R4 cle low", m_cle, 0);
        chk("R4 dq byte", m_dq, 8'hA5);
        chk("R11 no byte strobe on addr", m_ecc, 0);
    endtask

    task automatic t_data_write_min();
        access(3'd0, 1'b1, 8'h00, 8'h00);
        access(3'd4, 1'b1, 8'h3C, 8'h00);
        chk("R7 write total min", m_tot, 4);
        chk("R5 we one cycle", m_we, 1);
        chk("R5 latches low", m_cle + m_ale, 0);
        chk("R5 dq byte", m_dq, 8'h3C);
        chk("R5 oe", m_bad, 0);
        chk("R11 byte strobe count", m_ecc, 1);
        chk("R11 byte value", m_eccb, 8'h3C);
    endtask

    task automatic t_data_read();
        access(3'd0, 1'b1, 8'h0D, 8'h00);
        access(3'd4, 1'b0, 8'h00, 8'h5A);
        chk("R7 read total", m_tot, 8);
        chk("R6 re cycles", m_re, 4);
        chk("R6 no we", m_we, 0);
        chk("R2 hold 1", m_post, 1);
        chk("R6 byte at re rise", m_rd, 8'h59);
        chk("R11 read byte strobe", m_ecc, 1);
        chk("R11 read byte value", m_eccb, 8'h59);
    endtask

    task automatic t_chip_enable();
        access(3'd1, 1'b1, 8'h00, 8'h00);
        chk("R8 ce asserted", nand_ce_n, 0);
        access(3'd1, 1'b0, 8'h00, 8'h00);
        chk("R8 ctrl bit0 readback 0", m_rd[0], 0);
        access(3'd1, 1'b1, 8'h01, 8'h00);
        chk("R8 ce deasserted", nand_ce_n, 1);
    endtask

    task automatic t_ecc_restart();
        access(3'd1, 1'b1, 8'h03, 8'h00);
        chk("R9 pulse high", ecc_restart, 1);
        @(posedge clk); #1;
        chk("R9 pulse one cycle", ecc_restart, 0);
        access(3'd1, 1'b0, 8'h00, 8'h00);
        chk("R9 bit1 reads 0", m_rd[1], 0);
        access(3'd1, 1'b1, 8'h01, 8'h00);
        chk("R9 no pulse on 0", ecc_restart, 0);
    endtask

    task automatic t_ready_busy();
        @(negedge clk); nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        access(3'd1, 1'b0, 8'h00, 8'h00);
        chk("R10 busy", m_rd[7], 0);
        @(negedge clk); nand_rb = 1'b1;
        access(3'd1, 1'b0, 8'h00, 8'h00);
        chk("R10 one edge lag", m_rd[7], 0);
        access(3'd1, 1'b0, 8'h00, 8'h00);
        chk("R10 ready after two", m_rd[7], 1);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_cmd_default();
        t_addr_prog();
        t_data_write_min();
        t_data_read();
        t_chip_enable();
        t_ecc_restart();
        t_ready_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule